// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Peripheral Register Bank

This block is the peripheral end of an 8-bit multiplexed address/data bus driven by a host. The host places an address on the shared pins and raises a high-active latch strobe. While that strobe is high, an internal address latch follows the pins. When the strobe drops, the latch keeps the last address. The host then pulls either the low-active write strobe or the low-active read strobe. A write stores the pin value into the addressed entry of a small bank of registers. A read makes the block drive that entry back onto the pins.

The block never drives a strobe and starts no transfer. Pins and strobes arrive asynchronously, so they are brought into the local clock domain through one synchronizer chain of equal depth. This keeps data and strobes aligned. A write takes effect on the trailing (rising) edge of the write strobe. The whole register bank is exposed as a flat vector to the surrounding logic. The shared pins appear as separate input, output and output-enable signals, which the pad ring combines into one tristate pin.

Top module: `mbx_periph_regs`

## Requirements
- R1: After reset every register reads 0x00, the latched address is 0x00 and the output enable is low.
- R2: While the synchronized latch strobe is high, `addr_o` equals the synchronized pins. It updates SYNC_STAGES clock edges after a pin change. Once the strobe falls, `addr_o` holds the last value, whatever the pins do.
- R3: A write strobe low period that is followed by its rise stores the value that was on the pins in the last synchronized low cycle. The value goes into the register selected by the latched address, one clock after the synchronized rise.
- R4: `bus_oe_o` is high only while the synchronized read strobe is low and the synchronized latch strobe is low. Otherwise the pins are released.
- R5: While the block drives, `bus_o` carries the content of the addressed register.
- R6: A write to an address at or beyond NREGS changes no register.
- R7: A read from an address at or beyond NREGS drives 0x00.
- R8: If a write commits in the same cycle that a new latch strobe opens the latch, the data goes to the previously latched address. The latch then takes the new address.
- R9: If the pins change while the write strobe stays low, only the final value is stored. Exactly one register write happens per strobe.
- R10: A read leaves all register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 8 | Shared pins as seen from the pad (address or write data) |
| bus_o | output | 8 | Read data towards the pad |
| bus_oe_o | output | 1 | Pad output enable, high while the block drives |
| ale_i | input | 1 | Address latch strobe, high active |
| wr_n_i | input | 1 | Write strobe, low active |
| rd_n_i | input | 1 | Read strobe, low active |
| addr_o | output | 8 | Current address latch output |
| regs_o | output | 48 | Register bank contents, entry k in bits [8k+7:8k] |

## Verification
Two functions can fall into the same local cycle. One is the commit of a write on the rising edge of the write strobe. The other is a new opening of the address latch. The bench provokes this by releasing the write strobe, raising the latch strobe and presenting a new address on one and the same clock. The case is judged correct when the data lands in the register of the old address, the register of the new address keeps its value, and the latch ends up showing the new address. A second overlap, a read strobe held low while the latch strobe is high, must leave the pins released.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MBX_BUS_W = 8;
   typedef logic [MBX_BUS_W-1:0] mbx_word_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      if (STAGES < 2) $fatal(1, "mbx_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $fatal(1, "mbx_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
               else        chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mbx_addr_latch.sv
module mbx_addr_latch #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic [ADDR_W-1:0] pins_i,
   output logic [ADDR_W-1:0] held_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= '0;
      else if (open_i) held_q <= pins_i;
   end

   assign held_o = held_q;
   assign addr_o = open_i ? pins_i : held_q;

   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !open_i |=> $stable(held_q));
endmodule

// File: rtl/mbx_reg_bank.sv
module mbx_reg_bank #(
   parameter int unsigned NREGS  = 6,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [DATA_W-1:0]       rdata_o,
   output logic [NREGS*DATA_W-1:0] flat_o
);
   localparam logic [ADDR_W:0] NREGS_L = (ADDR_W+1)'(NREGS);

   initial begin
      if (NREGS < 1 || NREGS > (1 << ADDR_W))
         $fatal(1, "mbx_reg_bank: NREGS out of range for ADDR_W");
   end

   logic              hit;
   logic [DATA_W-1:0] mem [NREGS];

   assign hit = ({1'b0, addr_i} < NREGS_L);

   generate
      for (genvar k = 0; k < NREGS; k++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              mem[k] <= '0;
            else if (we_i && addr_i == ADDR_W'(k))   mem[k] <= wdata_i;
         end
         assign flat_o[k*DATA_W +: DATA_W] = mem[k];

         p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == ADDR_W'(k)) |=> (mem[k] == $past(wdata_i)));
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < NREGS; k++)
         if (addr_i == ADDR_W'(k)) rdata_o = mem[k];
   end

   p_oor_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !hit) |=> $stable(flat_o));
   p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(flat_o));
   p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rdata_o == '0));
endmodule

// File: rtl/mbx_periph_regs.sv
module mbx_periph_regs
   import mbx_pkg::*;
#(
   parameter int unsigned NREGS       = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [MBX_BUS_W-1:0]       bus_i,
   output logic [MBX_BUS_W-1:0]       bus_o,
   output logic                       bus_oe_o,
   input  logic                       ale_i,
   input  logic                       wr_n_i,
   input  logic                       rd_n_i,
   output logic [MBX_BUS_W-1:0]       addr_o,
   output logic [NREGS*MBX_BUS_W-1:0] regs_o
);
   localparam int unsigned BW = MBX_BUS_W;

   initial begin
      if (NREGS < 1 || NREGS > 256) $fatal(1, "NREGS must be 1..256");
      if (SYNC_STAGES < 2)          $fatal(1, "SYNC_STAGES must be >= 2");
   end

   mbx_word_t pins_s, wdata_q, held_addr, rdata;
   logic      ale_s, wr_s, rd_s, wr_s_d, commit;

   mbx_sync #(.WIDTH(BW), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pins (
      .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(pins_s));
   mbx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ale (
      .clk(clk), .rst_n(rst_n), .d_i(ale_i), .q_o(ale_s));
   mbx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wr (
      .clk(clk), .rst_n(rst_n), .d_i(wr_n_i), .q_o(wr_s));
   mbx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rd (
      .clk(clk), .rst_n(rst_n), .d_i(rd_n_i), .q_o(rd_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_s_d  <= 1'b1;
         wdata_q <= '0;
      end else begin
         wr_s_d <= wr_s;
         if (!wr_s) wdata_q <= pins_s;
      end
   end

   assign commit = wr_s & ~wr_s_d;

   mbx_addr_latch #(.ADDR_W(BW)) u_latch (
      .clk(clk), .rst_n(rst_n), .open_i(ale_s), .pins_i(pins_s),
      .held_o(held_addr), .addr_o(addr_o));

   mbx_reg_bank #(.NREGS(NREGS), .ADDR_W(BW), .DATA_W(BW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we_i(commit), .addr_i(held_addr),
      .wdata_i(wdata_q), .rdata_o(rdata), .flat_o(regs_o));

   assign bus_oe_o = ~rd_s & ~ale_s;
   assign bus_o    = bus_oe_o ? rdata : '0;

   p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);
   p_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ale_s || rd_s) |-> !bus_oe_o);
   p_read_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (bus_o == rdata));
   p_read_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_o && wr_s && wr_s_d) |=> $stable(regs_o));
endmodule

// File: tb/mbx_periph_regs_tb.sv
module mbx_periph_regs_tb;
   localparam int NR = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_i = 8'h00;
   logic [7:0]    bus_o;
   logic          bus_oe_o;
   logic          ale_i = 1'b0, wr_n_i = 1'b1, rd_n_i = 1'b1;
   logic [7:0]    addr_o;
   logic [NR*8-1:0] regs_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [NR];

   always #2 clk = ~clk;

   mbx_periph_regs #(.NREGS(NR), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .bus_o(bus_o),
      .bus_oe_o(bus_oe_o), .ale_i(ale_i), .wr_n_i(wr_n_i), .rd_n_i(rd_n_i),
      .addr_o(addr_o), .regs_o(regs_o));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk_bank(input string tag);
      for (int k = 0; k < NR; k++) chk(tag, regs_o[k*8 +: 8], model[k]);
   endtask

   task automatic latch_addr(input logic [7:0] a);
      bus_i = a; ale_i = 1'b1; wait_n(3);
      ale_i = 1'b0; wait_n(3);
   endtask

   task automatic host_write(input logic [7:0] d);
      bus_i = d; wr_n_i = 1'b0; wait_n(3);
      wr_n_i = 1'b1; wait_n(4);
   endtask

   task automatic host_read(input string tag, input logic [7:0] exp);
      bus_i = 8'hEE; rd_n_i = 1'b0; wait_n(3);
      chk({tag, " oe"}, bus_oe_o, 1'b1);
      chk({tag, " data"}, bus_o, exp);
      rd_n_i = 1'b1; wait_n(3);
      chk({tag, " released"}, bus_oe_o, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 addr", addr_o, 8'h00);
      chk("R1 oe", bus_oe_o, 1'b0);
      chk_bank("R1 regs");
   endtask

   task automatic t_latch();
      bus_i = 8'h21; ale_i = 1'b1; wait_n(3);
      chk("R2 follow first", addr_o, 8'h21);
      bus_i = 8'h03; wait_n(3);
      chk("R2 follow second", addr_o, 8'h03);
      ale_i = 1'b0; wait_n(3);
      bus_i = 8'hC4; wait_n(4);
      chk("R2 hold", addr_o, 8'h03);
   endtask

   task automatic t_write_read();
      for (int k = 0; k < NR; k++) begin
         latch_addr(8'(k));
         host_write(8'h11 * 8'(k + 1) ^ 8'hA0);
         model[k] = 8'h11 * 8'(k + 1) ^ 8'hA0;
      end
      chk_bank("R3 bank after writes");
      latch_addr(8'd2); host_read("R5 read reg2", model[2]);
      latch_addr(8'd5); host_read("R5 read reg5", model[5]);
      chk_bank("R10 bank after reads");
   endtask

   task automatic t_out_of_range();
      latch_addr(8'd6);  host_write(8'h77);
      latch_addr(8'hFF); host_write(8'h99);
      chk_bank("R6 oor write ignored");
      latch_addr(8'hFF); host_read("R7 oor read", 8'h00);
      latch_addr(8'd6);  host_read("R7 oor read 6", 8'h00);
   endtask

   task automatic t_read_gating();
      latch_addr(8'd1);
      bus_i = 8'd4; ale_i = 1'b1; rd_n_i = 1'b0; wait_n(4);
      chk("R4 ale high blocks drive", bus_oe_o, 1'b0);
      ale_i = 1'b0; wait_n(3);
      chk("R4 drive after ale falls", bus_oe_o, 1'b1);
      chk("R5 data after ale falls", bus_o, model[4]);
      rd_n_i = 1'b1; wait_n(3);
      chk("R4 idle released", bus_oe_o, 1'b0);
   endtask

   task automatic t_collision();
      latch_addr(8'd1);
      bus_i = 8'h5A; wr_n_i = 1'b0; wait_n(3);
      wr_n_i = 1'b1; ale_i = 1'b1; bus_i = 8'd3; wait_n(3);
      ale_i = 1'b0; wait_n(4);
      model[1] = 8'h5A;
      chk_bank("R8 commit to old address");
      chk("R8 new address latched", addr_o, 8'd3);
   endtask

   task automatic t_last_value();
      latch_addr(8'd0);
      bus_i = 8'h10; wr_n_i = 1'b0; wait_n(3);
      bus_i = 8'h20; wait_n(2);
      bus_i = 8'h3C; wait_n(3);
      wr_n_i = 1'b1; wait_n(4);
      model[0] = 8'h3C;
      chk_bank("R9 last value stored once");
   endtask

   initial begin
      for (int k = 0; k < NR; k++) model[k] = 8'h00;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_latch();
      t_write_read();
      t_out_of_range();
      t_read_gating();
      t_collision();
      t_last_value();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule